// File: doc/BRIEF.md
# Dual Write-Combining Store Queue with Burst Flush

This block sits between a processor core and external memory and collects 32-bit stores into two 32-byte write-combining buffers. An access falls in the queue window when the top six address bits equal `111000`. Address bit 5 picks one of the two queues, and bits [4:2] pick the word inside that queue. The core fills a queue word by word. It then issues a flush command, and the whole queue goes out to memory as one aligned 32-byte burst of eight beats.

The burst destination is built from three parts: the flush address, the queue number, and a 3-bit upper-address field held in a small configuration register for each queue. When a flush is accepted, the queue contents are copied into the burst engine, and the burst then drains at the pace set by the memory side's ready signal.

The core keeps filling the idle queue while the other queue drains, with no penalty. A store or flush that cannot be taken yet is held back with a stall. Only the untranslated address path is modelled.

Top module: `wcq_top`

## Requirements
- R1: An access whose address bits [31:26] differ from `111000` is ignored: it raises no stall, changes no queue word and starts no burst.
- R2: A store in the window writes `st_data` into queue `st_addr[5]` (0 or 1) at word index `st_addr[4:2]`.
- R3: A burst sends the eight words of the queue in ascending index order, 0 through 7. It advances one beat on each cycle where `mem_valid` and `mem_ready` are both high, and `mem_last` is high on the eighth beat only.
- R4: The burst address is `{cfg[q][4:2], fl_addr[25:6], q, 5'b00000}`, where q is `fl_addr[5]`. The low five bits are always zero.
- R5: Both configuration registers reset to zero. A write keeps only bits [4:2], and a read returns those bits in place with every other bit zero. `cfg_sel` 0 selects the register of queue 0 and 1 selects the register of queue 1.
- R6: A store to the queue that is not draining is accepted in the same cycle, with no stall.
- R7: A store to the draining queue keeps `core_stall` high until the cycle after that queue's last beat is accepted, and is accepted in that cycle.
- R8: A flush presented while a burst is in progress stalls until the burst ends.
- R9: Burst data reflect exactly the stores accepted before the flush was accepted. A store and a flush to the same queue in the same cycle stall.
- R10: Reset leaves `mem_valid` and `core_stall` low and no queue busy.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| fl_valid | input | 1 | Flush request |
| fl_addr | input | 32 | Flush address |
| core_stall | output | 1 | Requests this cycle are not taken |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration register |
| mem_valid | output | 1 | Burst beat valid |
| mem_addr | output | 29 | Burst start address |
| mem_data | output | 32 | Burst beat data |
| mem_last | output | 1 | Final beat of the burst |
| mem_ready | input | 1 | Memory accepts the beat |

## Verification
The assertions watch the stall rules on every cycle:
- a store to the draining queue is held;
- a store to the other queue passes;
- an out-of-window access never stalls;
- a flush during a burst waits.

They also check the burst's alignment, its hold under back-pressure and the idle state after reset.

Some behaviour only the bench scenarios can show:
- the order and values of the eight beats;
- the destination address composed from every configuration value;
- the masking of the configuration registers;
- the exact release cycle of a held store;
- the snapshot taken when a flush is accepted.

// File: rtl/wcq_pkg.sv
// Shared constants and types for the write-combining store queue.
// Assumes two queues of eight 32-bit words each, and a 29-bit physical address.
package wcq_pkg;
    localparam int DW       = 32;
    localparam int AW       = 32;
    localparam int PAW      = 29;
    localparam int NQ       = 2;
    localparam int NW       = 8;
    localparam int WIX      = $clog2(NW);
    localparam int QBIT     = WIX + 2;
    localparam int HIW      = 3;
    localparam int HILO     = 2;
    localparam int TAGW     = 6;
    localparam logic [TAGW-1:0] WIN_TAG = 6'b111000;

    typedef logic [NW-1:0][DW-1:0] qwords_t;
endpackage

// File: rtl/wcq_cfg.sv
// Upper-address configuration registers, one per queue.
// Only bits [4:2] are stored. Reads return those bits in place with all
// other bits zero. Both registers reset to zero.
module wcq_cfg
    import wcq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     sel,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic [NQ-1:0][HIW-1:0]   hi
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[DW-1:HILO+HIW], wdata[HILO-1:0]};

    // Register update: keep the implemented field only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
        end else if (we) begin
            hi[sel] <= wdata[HILO+HIW-1:HILO];
        end
    end

    // Readback of the selected register.
    always_comb begin
        rdata = '0;
        rdata[HILO+HIW-1:HILO] = hi[sel];
    end

    p_cfg_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(hi));
endmodule

// File: rtl/wcq_bank.sv
// Storage for both queues. One word is written per cycle; all words of a
// chosen queue are read in parallel. Contents are not reset.
module wcq_bank
    import wcq_pkg::*;
(
    input  logic            clk,
    input  logic            we,
    input  logic            wq,
    input  logic [WIX-1:0]  widx,
    input  logic [DW-1:0]   wdata,
    input  logic            rq,
    output qwords_t         rwords
);
    qwords_t words [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        // Word write into queue g.
        always_ff @(posedge clk) begin
            if (we && (wq == 1'(g))) begin
                words[g][widx] <= wdata;
            end
        end
    end

    // Parallel read of the selected queue.
    assign rwords = words[rq];
endmodule

// File: rtl/wcq_burst.sv
// Burst engine. On start it captures eight words, the destination address
// and the queue id, then sends the words in ascending order, one per
// ready cycle. Assumes start is given only while idle.
module wcq_burst
    import wcq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_q,
    input  logic [PAW-1:0]   start_addr,
    input  qwords_t          start_words,
    output logic             busy,
    output logic             busy_q,
    output logic             mem_valid,
    output logic [PAW-1:0]   mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             mem_last,
    input  logic             mem_ready
);
    qwords_t          snap;
    logic [WIX-1:0]   beat;
    logic             active;
    logic             qid;
    logic [PAW-1:0]   addr_q;

    // Control: activity flag, beat counter, queue id, address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
            qid    <= 1'b0;
            addr_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
            qid    <= start_q;
            addr_q <= start_addr;
        end else if (active && mem_ready) begin
            if (beat == WIX'(NW-1)) begin
                active <= 1'b0;
            end
            beat <= beat + 1'b1;
        end
    end

    // Data snapshot taken at flush acceptance.
    always_ff @(posedge clk) begin
        if (start) begin
            snap <= start_words;
        end
    end

    assign busy      = active;
    assign busy_q    = qid;
    assign mem_valid = active;
    assign mem_addr  = addr_q;
    assign mem_data  = snap[beat];
    assign mem_last  = active && (beat == WIX'(NW-1));

    p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[QBIT-1:0] == '0));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_last && mem_ready |=> !mem_valid || $past(start));
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_valid);
endmodule

// File: rtl/wcq_top.sv
// Dual write-combining store queue top. It decodes the queue window,
// applies the stall rules, composes the burst address and connects the
// banks, the configuration registers and the burst engine.
// Assumes one store and one flush request port, each held by the core
// while core_stall is high.
module wcq_top
    import wcq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic             fl_valid,
    input  logic [AW-1:0]    fl_addr,
    output logic             core_stall,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic             mem_valid,
    output logic [PAW-1:0]   mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             mem_last,
    input  logic             mem_ready
);
    logic                    st_hit, fl_hit, st_q, fl_q;
    logic                    st_take, fl_take;
    logic                    eng_busy, eng_q;
    logic [NQ-1:0]           q_busy;
    logic [NQ-1:0][HIW-1:0]  hi;
    qwords_t                 fl_words;
    logic [PAW-1:0]          fl_dest;
    logic                    unused_abits;

    assign unused_abits = ^{st_addr[AW-TAGW-1:QBIT+1], st_addr[1:0], fl_addr[QBIT-1:0]};

    // Window decode and queue selection for both request ports.
    always_comb begin
        st_hit = st_valid && (st_addr[AW-1:AW-TAGW] == WIN_TAG);
        fl_hit = fl_valid && (fl_addr[AW-1:AW-TAGW] == WIN_TAG);
        st_q   = st_addr[QBIT];
        fl_q   = fl_addr[QBIT];
    end

    // Per-queue draining flags from the engine state.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_busy[i] = eng_busy && (eng_q == 1'(i));
        end
    end

    // Stall: store to a draining queue, flush during a burst, or a store
    // and flush to the same queue in one cycle.
    always_comb begin
        core_stall = (st_hit && q_busy[st_q])
                   || (fl_hit && eng_busy)
                   || (st_hit && fl_hit && (st_q == fl_q));
        st_take    = st_hit && !core_stall;
        fl_take    = fl_hit && !core_stall;
    end

    // Destination: upper bits from config, middle from flush address,
    // queue bit, zero low bits.
    assign fl_dest = {hi[fl_q], fl_addr[PAW-HIW-1:QBIT+1], fl_q, {QBIT{1'b0}}};

    wcq_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .hi    (hi)
    );

    wcq_bank u_bank (
        .clk    (clk),
        .we     (st_take),
        .wq     (st_q),
        .widx   (st_addr[QBIT-1:2]),
        .wdata  (st_data),
        .rq     (fl_q),
        .rwords (fl_words)
    );

    wcq_burst u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (fl_take),
        .start_q     (fl_q),
        .start_addr  (fl_dest),
        .start_words (fl_words),
        .busy        (eng_busy),
        .busy_q      (eng_q),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .mem_last    (mem_last),
        .mem_ready   (mem_ready)
    );

    p_busy_store_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit && mem_valid && (st_q == eng_q) |-> core_stall);
    p_other_queue_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit && !fl_valid && !(mem_valid && (st_q == eng_q)) |-> !core_stall);
    p_miss_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_hit && !fl_hit |-> !core_stall);
    p_flush_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_hit && mem_valid |-> core_stall);
    p_same_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit && fl_hit && (st_q == fl_q) |=> !$past(u_bank.we));
endmodule

// File: tb/wcq_top_test.sv
// Self-checking bench: sweeps every queue and configuration value under
// several memory ready patterns, then exercises the stall corner cases.
module wcq_top_test;
    localparam int CLK_NS   = 10;
    localparam int WDOG_MAX = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, fl_valid = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, fl_addr = '0;
    logic        core_stall;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_valid, mem_last, mem_ready = 1'b1;
    logic [28:0] mem_addr;
    logic [31:0] mem_data;

    int total = 0, bad = 0, ncyc = 0, rmode = 0, bcount = 0, wdog = 0;
    logic [31:0] got_d [8];
    logic        got_l [8];
    logic [28:0] got_a;
    logic        prev_wait = 1'b0;
    logic [28:0] prev_a;
    logic [31:0] prev_d;
    logic [31:0] expw [8];

    wcq_top uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .fl_valid(fl_valid), .fl_addr(fl_addr),
        .core_stall(core_stall), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_last(mem_last),
        .mem_ready(mem_ready)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        wdog++;
        if (wdog > WDOG_MAX) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wdog, WDOG_MAX);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Memory model: ready pattern, beat capture, hold check (R11).
    always @(negedge clk) begin
        case (rmode)
            0: mem_ready = 1'b1;
            1: mem_ready = ncyc[0];
            2: mem_ready = (ncyc % 3) != 0;
            default: mem_ready = 1'b0;
        endcase
        ncyc++;
        if (prev_wait)
            chk(mem_valid && mem_addr == prev_a && mem_data == prev_d, "R11 hold", mem_data, prev_d);
        prev_wait = mem_valid && !mem_ready;
        prev_a = mem_addr;
        prev_d = mem_data;
        if (mem_valid && mem_ready && bcount < 8) begin
            got_d[bcount] = mem_data;
            got_l[bcount] = mem_last;
            if (bcount == 0) got_a = mem_addr;
            bcount++;
        end
    end

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        while (core_stall) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_flush(input logic [31:0] a);
        @(negedge clk);
        fl_valid = 1'b1; fl_addr = a;
        #1;
        while (core_stall) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        fl_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_burst();
        while (bcount < 8) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_burst(input string tag, input logic [28:0] ea);
        chk(got_a == ea, {tag, " R4 addr"}, 32'(got_a), 32'(ea));
        for (int i = 0; i < 8; i++) begin
            chk(got_d[i] == expw[i], {tag, " R3 beat data"}, got_d[i], expw[i]);
            chk(got_l[i] == (i == 7), {tag, " R3 last flag"}, 32'(got_l[i]), 32'(i == 7));
        end
    endtask

    function automatic logic [31:0] dval(input int q, input int w, input int k);
        return 32'h5A00_0000 ^ (q << 28) ^ (k << 16) ^ (w * 32'h0111) ^ 32'h0000_00C3;
    endfunction

    logic [31:0] fa;
    logic [28:0] ea;
    int n_after;

    initial begin
        rmode = 0;
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state.
        chk(!mem_valid, "R10 mem_valid after reset", 32'(mem_valid), 0);
        chk(!core_stall, "R10 stall after reset", 32'(core_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: config reset value and masking.
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 0, "R5 cfg0 reset", cfg_rdata, 0);
        cfg_sel = 1'b1; #1;
        chk(cfg_rdata == 0, "R5 cfg1 reset", cfg_rdata, 0);
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 32'h1C, "R5 cfg0 mask", cfg_rdata, 32'h1C);
        cfg_sel = 1'b1; #1;
        chk(cfg_rdata == 0, "R5 cfg1 untouched", cfg_rdata, 0);

        // Sweep: each queue, each config value, three ready patterns (R2 R3 R4 R5).
        for (int q = 0; q < 2; q++) begin
            for (int k = 0; k < 8; k++) begin
                cfg_write(q[0], 32'hFFFF_FFE3 | (k << 2));
                cfg_sel = q[0]; #1;
                chk(cfg_rdata == (k << 2), "R5 cfg readback", cfg_rdata, k << 2);
                for (int w = 7; w >= 0; w--) begin
                    expw[w] = dval(q, w, k);
                    do_store(32'hE000_0000 | (q << 5) | (w << 2), expw[w]);
                end
                fa = 32'hE000_0000 | (q << 5) | (((k * 32'h1357 + q * 32'h9A3) & 32'hFFFFF) << 6) | 32'h1C;
                ea = {3'(k), fa[25:6], q[0], 5'b0};
                rmode = k % 3;
                bcount = 0;
                do_flush(fa);
                wait_burst();
                check_burst("R2 sweep", ea);
            end
        end
        rmode = 0;

        // R1: out-of-window store and flush are ignored.
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'hE400_0004; st_data = 32'hDEAD_BEEF;
        fl_valid = 1'b1; fl_addr = 32'h6000_0000;
        #1;
        chk(!core_stall, "R1 no stall outside window", 32'(core_stall), 0);
        @(posedge clk); #1;
        st_valid = 1'b0; fl_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_valid, "R1 no burst outside window", 32'(mem_valid), 0);
        for (int w = 0; w < 8; w++) expw[w] = dval(0, w, 7);
        bcount = 0;
        do_flush(32'hE000_0000);
        wait_burst();
        check_burst("R1 contents kept", {3'd7, 20'd0, 1'b0, 5'b0});

        // Fill both queues for the concurrency cases.
        for (int w = 0; w < 8; w++) begin
            do_store(32'hE000_0000 | (w << 2), 32'hA000_0000 + w);
            do_store(32'hE000_0020 | (w << 2), 32'hB000_0000 + w);
        end
        rmode = 3;
        bcount = 0;
        do_flush(32'hE000_0040);
        // R6: store to the other queue during the drain.
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'hE000_002C; st_data = 32'hCAFE_0003;
        #1;
        chk(!core_stall, "R6 other queue no stall", 32'(core_stall), 0);
        @(posedge clk); #1;
        st_valid = 1'b0;
        // R8: flush during the drain stalls.
        @(negedge clk);
        fl_valid = 1'b1; fl_addr = 32'hE000_0020;
        #1;
        chk(core_stall, "R8 flush stalls while busy", 32'(core_stall), 1);
        fl_valid = 1'b0;
        // R7: store to the draining queue stalls until after the last beat.
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'hE000_0000; st_data = 32'hFACE_0000;
        #1;
        chk(core_stall, "R7 draining queue stalls", 32'(core_stall), 1);
        rmode = 0;
        n_after = 0;
        while (core_stall) begin
            @(negedge clk); #1;
            if (core_stall && bcount == 8) n_after++;
        end
        chk(bcount == 8, "R7 release after last beat", bcount, 8);
        chk(n_after == 1, "R7 release cycle", n_after, 1);
        @(posedge clk); #1;
        st_valid = 1'b0;
        // R9: burst held the contents from before the flush.
        for (int w = 0; w < 8; w++) expw[w] = 32'hA000_0000 + w;
        check_burst("R9 snapshot", {3'd7, 20'd1, 1'b0, 5'b0});

        // R9: same-cycle store and flush to one queue stall.
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'hE000_0024; st_data = 32'h0BAD_0001;
        fl_valid = 1'b1; fl_addr = 32'hE000_0020;
        #1;
        chk(core_stall, "R9 same queue store+flush stall", 32'(core_stall), 1);
        st_valid = 1'b0;
        bcount = 0;
        #1;
        @(posedge clk); #1;
        fl_valid = 1'b0;
        wait_burst();
        for (int w = 0; w < 8; w++) expw[w] = 32'hB000_0000 + w;
        expw[3] = 32'hCAFE_0003;
        check_burst("R6 R9 queue1", {3'd7, 20'd0, 1'b1, 5'b0});

        // R2: queue 0 now holds the released store at word 0.
        for (int w = 0; w < 8; w++) expw[w] = 32'hA000_0000 + w;
        expw[0] = 32'hFACE_0000;
        bcount = 0;
        rmode = 1;
        do_flush(32'hE3FF_FFC0);
        wait_burst();
        check_burst("R2 queue0 update", {3'd7, 20'hFFFFF, 1'b0, 5'b0});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule